// File: doc/BRIEF.md
# LIN frame status and interrupt logic

This block keeps the sticky flags of a LIN controller and turns them into two interrupt lines. The protocol engine sends it one-cycle event pulses: break/sync detected, identifier accepted, transmit response finished, receive response finished, and one strobe for each error source. Software acts on it through write strobes. It can clear chosen flags, load the interrupt enables, and write a two-bit command that says what the node does in the current frame.

Break-in-data is handled here. A break/sync may arrive while a response is still moving, even when it lands on top of a data byte. On a slave node the block then aborts the response: it returns the command to idle, flags a bit error if the node was transmitting, and flags a framing error if it was receiving. On a master node the abort is left to software. Writing the idle command over a command in progress raises the abort error, and a header command may be written right after it. Every break/sync raises a frame-start strobe and drops the pending ok flags. The error flags stay set until software clears them.

Top module: `lin_frame_status`

## Requirements
- R1: Each bit of `err_strobe` sets the error flag at the same position in `err_word` on the next clock edge. The positions are: 7 abort, 6 timeout, 5 overrun, 4 framing, 3 sync, 2 parity, 1 checksum, 0 bit error.
- R2: `status` bit 2 is identifier-ok, bit 1 is transmit-ok and bit 0 is receive-ok. Each is set on the edge that follows its event pulse. Bit 3 is high whenever any bit of `err_word` is high.
- R3: Flags are sticky. While `clr_wr` is high, an edge clears the ok and error flags selected by `clr_ok_mask` and `clr_err_mask`. A set event for the same flag in the same cycle wins, and the flag stays 1.
- R4: Command codes are 0 idle, 1 receive response, 2 transmit response, 3 transmit header. A `cmd_wr` loads `cmd_wdata`. The command returns to idle on the matching completion pulse: receive-done for 1, transmit-done for 2, identifier-ok for 3. A completion pulse that does not match leaves the command unchanged.
- R5: On a slave node (`node_master` = 0), a break/sync seen while the command is 2 sets error bit 0 and returns the command to idle.
- R6: On a slave node, a break/sync seen while the command is 1 sets error bit 4 and returns the command to idle. A break/sync while the command is idle or 3 sets no error.
- R7: On a master node, writing command 0 while the command is not 0 sets error bit 7. Writing 0 while the command is already idle sets nothing. A break/sync on a master node leaves both the command and the error flags unchanged. A header command written after an abort is accepted.
- R8: `frame_start` is high in the same cycle as `ev_brk_sync`. The edge ends that cycle clears status bits 2..0 unless an ok event arrives in that cycle. The error flags are kept.
- R9: `en_wr` loads `en_q`, whose bits sit at the same positions as the `status` bits. `irq_err` is status bit 3 AND `en_q` bit 3.
- R10: `irq_frame` is high when any of status bits 2..0 is high together with the `en_q` bit at the same position.
- R11: After reset, `status`, `err_word`, `cmd_q`, `en_q` and both interrupt lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| node_master | input | 1 | 1 = master role, 0 = slave role |
| ev_brk_sync | input | 1 | Break/sync field detected |
| ev_id_ok | input | 1 | Identifier accepted |
| ev_tx_done | input | 1 | Transmit response finished |
| ev_rx_done | input | 1 | Receive response finished |
| err_strobe | input | 8 | One-cycle error strobes, at the same positions as the error flags |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 2 | Command value to write |
| en_wr | input | 1 | Enable write strobe |
| en_wdata | input | 4 | Interrupt enable value to write |
| clr_wr | input | 1 | Flag clear strobe |
| clr_ok_mask | input | 3 | Ok flags to clear |
| clr_err_mask | input | 8 | Error flags to clear |
| status | output | 4 | Summary error flag and ok flags |
| err_word | output | 8 | Sticky error flags |
| cmd_q | output | 2 | Current command |
| en_q | output | 4 | Interrupt enables |
| frame_start | output | 1 | New frame begins |
| irq_err | output | 1 | Error interrupt |
| irq_frame | output | 1 | Ok-event interrupt |

## Verification
Every flag is one register deep. A wrong set, clear or priority decision therefore shows on `err_word` or `status` at the first negative edge after the edge that caused it, and it stays visible because the flags are sticky. A command register holding the wrong value shows on `cmd_q` at once. Its later effect shows when the next break/sync raises the wrong error bit, or no error bit, one edge after that break. A wrong enable or interrupt mapping shows combinationally on `irq_err` or `irq_frame` in the same cycle that the flags or enables change.

// File: rtl/lin_stat_pkg.sv
package lin_stat_pkg;
  localparam int ERR_W  = 8;
  localparam int OK_W   = 3;
  localparam int STAT_W = OK_W + 1;
  localparam int CMD_W  = 2;

  // error word positions
  localparam int E_ABORT = 7;
  localparam int E_TOUT  = 6;
  localparam int E_OVR   = 5;
  localparam int E_FRM   = 4;
  localparam int E_SYNC  = 3;
  localparam int E_PAR   = 2;
  localparam int E_CHK   = 1;
  localparam int E_BIT   = 0;

  // status word positions
  localparam int S_ERR = 3;
  localparam int S_ID  = 2;
  localparam int S_TX  = 1;
  localparam int S_RX  = 0;

  typedef enum logic [CMD_W-1:0] {
    CMD_IDLE  = 2'd0,
    CMD_RXRSP = 2'd1,
    CMD_TXRSP = 2'd2,
    CMD_HDR   = 2'd3
  } lin_cmd_e;

  // next value of one sticky flag: a set beats a clear
  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  // OR of flags each gated by the enable at the same position
  function automatic logic gated_any(input logic [OK_W-1:0] flg, input logic [OK_W-1:0] en);
    return |(flg & en);
  endfunction

  function automatic logic cmd_is_resp(input lin_cmd_e c);
    return (c == CMD_RXRSP) || (c == CMD_TXRSP);
  endfunction
endpackage

// File: rtl/lin_cmd_ctrl.sv
module lin_cmd_ctrl
  import lin_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             node_master,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic             ev_brk_sync,
  input  logic             ev_id_ok,
  input  logic             ev_tx_done,
  input  logic             ev_rx_done,
  output logic [CMD_W-1:0] cmd_o,
  output logic             resp_active,
  output logic             brk_abort_tx,
  output logic             brk_abort_rx,
  output logic             sw_abort
);
  lin_cmd_e cmd_q, cmd_d;
  logic     done_match;

  always_comb begin
    resp_active  = cmd_is_resp(cmd_q);
    brk_abort_tx = ev_brk_sync && !node_master && (cmd_q == CMD_TXRSP);
    brk_abort_rx = ev_brk_sync && !node_master && (cmd_q == CMD_RXRSP);
    sw_abort     = node_master && cmd_wr && (cmd_wdata == CMD_IDLE) && (cmd_q != CMD_IDLE);
    unique case (cmd_q)
      CMD_RXRSP: done_match = ev_rx_done;
      CMD_TXRSP: done_match = ev_tx_done;
      CMD_HDR:   done_match = ev_id_ok;
      default:   done_match = 1'b0;
    endcase
  end

  always_comb begin
    cmd_d = cmd_q;
    if (cmd_wr)
      cmd_d = lin_cmd_e'(cmd_wdata);
    else if (brk_abort_tx || brk_abort_rx)
      cmd_d = CMD_IDLE;
    else if (done_match)
      cmd_d = CMD_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= CMD_IDLE;
    else        cmd_q <= cmd_d;
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/lin_flag_bank.sv
module lin_flag_bank
  import lin_stat_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= sticky_next(q, set_i[i], clr_i[i]);
    end
    assign q_o[i] = q;
  end
endmodule

// File: rtl/lin_irq_map.sv
module lin_irq_map
  import lin_stat_pkg::*;
(
  input  logic [OK_W-1:0]   ok_flags,
  input  logic [ERR_W-1:0]  err_flags,
  input  logic [STAT_W-1:0] en,
  output logic [STAT_W-1:0] status,
  output logic              irq_err,
  output logic              irq_frame
);
  logic err_sum;

  assign err_sum   = |err_flags;
  assign status    = {err_sum, ok_flags};
  assign irq_err   = err_sum & en[S_ERR];
  assign irq_frame = gated_any(ok_flags, en[OK_W-1:0]);
endmodule

// File: rtl/lin_frame_status.sv
module lin_frame_status
  import lin_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              node_master,
  input  logic              ev_brk_sync,
  input  logic              ev_id_ok,
  input  logic              ev_tx_done,
  input  logic              ev_rx_done,
  input  logic [ERR_W-1:0]  err_strobe,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_wdata,
  input  logic              en_wr,
  input  logic [STAT_W-1:0] en_wdata,
  input  logic              clr_wr,
  input  logic [OK_W-1:0]   clr_ok_mask,
  input  logic [ERR_W-1:0]  clr_err_mask,
  output logic [STAT_W-1:0] status,
  output logic [ERR_W-1:0]  err_word,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [STAT_W-1:0] en_q,
  output logic              frame_start,
  output logic              irq_err,
  output logic              irq_frame
);
  // named internal events, also used by the checker
  logic              resp_active;
  logic              brk_abort_tx;
  logic              brk_abort_rx;
  logic              sw_abort;
  logic              new_frame;
  logic [ERR_W-1:0]  err_set;
  logic [ERR_W-1:0]  err_clr;
  logic [OK_W-1:0]   ok_set;
  logic [OK_W-1:0]   ok_clr;
  logic [OK_W-1:0]   ok_flags;

  lin_cmd_ctrl u_cmd (
    .clk          (clk),
    .rst_n        (rst_n),
    .node_master  (node_master),
    .cmd_wr       (cmd_wr),
    .cmd_wdata    (cmd_wdata),
    .ev_brk_sync  (ev_brk_sync),
    .ev_id_ok     (ev_id_ok),
    .ev_tx_done   (ev_tx_done),
    .ev_rx_done   (ev_rx_done),
    .cmd_o        (cmd_q),
    .resp_active  (resp_active),
    .brk_abort_tx (brk_abort_tx),
    .brk_abort_rx (brk_abort_rx),
    .sw_abort     (sw_abort)
  );

  assign new_frame   = ev_brk_sync;
  assign frame_start = new_frame;

  always_comb begin
    err_set          = err_strobe;
    err_set[E_ABORT] = err_strobe[E_ABORT] | sw_abort;
    err_set[E_FRM]   = err_strobe[E_FRM]   | brk_abort_rx;
    err_set[E_BIT]   = err_strobe[E_BIT]   | brk_abort_tx;
    err_clr          = clr_wr ? clr_err_mask : '0;
    ok_set           = '0;
    ok_set[S_ID]     = ev_id_ok;
    ok_set[S_TX]     = ev_tx_done;
    ok_set[S_RX]     = ev_rx_done;
    ok_clr           = (clr_wr ? clr_ok_mask : '0) | {OK_W{new_frame}};
  end

  lin_flag_bank #(.W(ERR_W)) u_err_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (err_set),
    .clr_i (err_clr),
    .q_o   (err_word)
  );

  lin_flag_bank #(.W(OK_W)) u_ok_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ok_set),
    .clr_i (ok_clr),
    .q_o   (ok_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_wdata;
  end

  lin_irq_map u_irq (
    .ok_flags  (ok_flags),
    .err_flags (err_word),
    .en        (en_q),
    .status    (status),
    .irq_err   (irq_err),
    .irq_frame (irq_frame)
  );
endmodule

// File: rtl/lin_frame_status_chk.sv
module lin_frame_status_chk
  import lin_stat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              node_master,
  input logic              ev_brk_sync,
  input logic              ev_id_ok,
  input logic              ev_tx_done,
  input logic              ev_rx_done,
  input logic              cmd_wr,
  input logic [CMD_W-1:0]  cmd_wdata,
  input logic              clr_wr,
  input logic [STAT_W-1:0] en_q,
  input logic [CMD_W-1:0]  cmd_q,
  input logic [ERR_W-1:0]  err_word,
  input logic [STAT_W-1:0] status,
  input logic              irq_frame,
  input logic              brk_abort_tx,
  input logic              brk_abort_rx,
  input logic              sw_abort
);
  assert_sticky_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((err_word & $past(err_word)) == $past(err_word)));

  assert_brk_tx_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_abort_tx && !cmd_wr |=> (cmd_q == 2'd0) && err_word[E_BIT]);

  assert_brk_rx_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_abort_rx && !cmd_wr |=> (cmd_q == 2'd0) && err_word[E_FRM]);

  assert_sw_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    node_master && cmd_wr && (cmd_wdata == 2'd0) && (cmd_q != 2'd0) |=> err_word[E_ABORT]);

  assert_master_no_brk_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_brk_sync && node_master |-> !brk_abort_tx && !brk_abort_rx);

  assert_slave_no_sw_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !node_master |-> !sw_abort);

  assert_frame_clears_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_brk_sync && !ev_id_ok && !ev_tx_done && !ev_rx_done |=> (status[OK_W-1:0] == '0));

  assert_irq_frame_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[OK_W-1:0] == '0) |-> !irq_frame);
endmodule

bind lin_frame_status lin_frame_status_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .node_master  (node_master),
  .ev_brk_sync  (ev_brk_sync),
  .ev_id_ok     (ev_id_ok),
  .ev_tx_done   (ev_tx_done),
  .ev_rx_done   (ev_rx_done),
  .cmd_wr       (cmd_wr),
  .cmd_wdata    (cmd_wdata),
  .clr_wr       (clr_wr),
  .en_q         (en_q),
  .cmd_q        (cmd_q),
  .err_word     (err_word),
  .status       (status),
  .irq_frame    (irq_frame),
  .brk_abort_tx (brk_abort_tx),
  .brk_abort_rx (brk_abort_rx),
  .sw_abort     (sw_abort)
);

// File: tb/test_lin_frame_status.sv
`timescale 1ns/1ps
module test_lin_frame_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       node_master = 1'b0;
  logic       ev_brk_sync = 1'b0, ev_id_ok = 1'b0, ev_tx_done = 1'b0, ev_rx_done = 1'b0;
  logic [7:0] err_strobe = '0;
  logic       cmd_wr = 1'b0;
  logic [1:0] cmd_wdata = '0;
  logic       en_wr = 1'b0;
  logic [3:0] en_wdata = '0;
  logic       clr_wr = 1'b0;
  logic [2:0] clr_ok_mask = '0;
  logic [7:0] clr_err_mask = '0;
  logic [3:0] status;
  logic [7:0] err_word;
  logic [1:0] cmd_q;
  logic [3:0] en_q;
  logic       frame_start, irq_err, irq_frame;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lin_frame_status i_lin_frame_status (
    .clk(clk), .rst_n(rst_n), .node_master(node_master),
    .ev_brk_sync(ev_brk_sync), .ev_id_ok(ev_id_ok), .ev_tx_done(ev_tx_done),
    .ev_rx_done(ev_rx_done), .err_strobe(err_strobe), .cmd_wr(cmd_wr),
    .cmd_wdata(cmd_wdata), .en_wr(en_wr), .en_wdata(en_wdata), .clr_wr(clr_wr),
    .clr_ok_mask(clr_ok_mask), .clr_err_mask(clr_err_mask), .status(status),
    .err_word(err_word), .cmd_q(cmd_q), .en_q(en_q), .frame_start(frame_start),
    .irq_err(irq_err), .irq_frame(irq_frame)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // inputs set before call are applied for one edge; outputs sampled at the next negedge
  task automatic step();
    @(negedge clk);
    ev_brk_sync = 0; ev_id_ok = 0; ev_tx_done = 0; ev_rx_done = 0;
    err_strobe = '0; cmd_wr = 0; en_wr = 0; clr_wr = 0;
    clr_ok_mask = '0; clr_err_mask = '0;
  endtask

  task automatic write_cmd(input logic [1:0] c);
    cmd_wr = 1; cmd_wdata = c; step();
  endtask

  task automatic clear_all();
    clr_wr = 1; clr_ok_mask = 3'h7; clr_err_mask = 8'hFF; step();
  endtask

  task automatic t_reset();
    chk("R11 status", status, 0);
    chk("R11 err_word", err_word, 0);
    chk("R11 cmd", cmd_q, 0);
    chk("R11 en", en_q, 0);
    chk("R11 irqs", {irq_err, irq_frame}, 0);
  endtask

  task automatic t_errors();
    err_strobe = 8'h24; step();
    chk("R1 err set", err_word, 8'h24);
    chk("R2 summary", status[3], 1);
    err_strobe = 8'h81; step();
    chk("R1 err accumulate", err_word, 8'hA5);
    clr_wr = 1; clr_err_mask = 8'h04; step();
    chk("R3 partial clear", err_word, 8'hA1);
    clr_wr = 1; clr_err_mask = 8'h20; err_strobe = 8'h20; step();
    chk("R3 set beats clear", err_word, 8'hA1);
    clear_all();
    chk("R3 clear all", err_word, 0);
    chk("R2 summary low", status[3], 0);
  endtask

  task automatic t_ok();
    ev_id_ok = 1; step();
    chk("R2 id ok", status, 4'h4);
    ev_tx_done = 1; step();
    chk("R2 tx ok", status, 4'h6);
    ev_rx_done = 1; step();
    chk("R2 rx ok", status, 4'h7);
    step();
    chk("R3 ok sticky", status, 4'h7);
    clr_wr = 1; clr_ok_mask = 3'b010; step();
    chk("R3 ok clear mask", status, 4'h5);
    clr_wr = 1; clr_ok_mask = 3'b001; ev_rx_done = 1; step();
    chk("R3 ok set beats clear", status, 4'h5);
    clear_all();
  endtask

  task automatic t_cmd();
    node_master = 0;
    write_cmd(2'd1);
    chk("R4 cmd rx load", cmd_q, 1);
    ev_tx_done = 1; step();
    chk("R4 mismatched done", cmd_q, 1);
    ev_rx_done = 1; step();
    chk("R4 rx done idle", cmd_q, 0);
    write_cmd(2'd2);
    ev_tx_done = 1; step();
    chk("R4 tx done idle", cmd_q, 0);
    write_cmd(2'd3);
    ev_id_ok = 1; step();
    chk("R4 hdr id idle", cmd_q, 0);
    chk("R4 no error", err_word, 0);
    clear_all();
  endtask

  task automatic t_slave_tx();
    node_master = 0;
    write_cmd(2'd2);
    ev_brk_sync = 1;
    #1 chk("R8 frame_start same cycle", frame_start, 1);
    step();
    chk("R5 bit error", err_word, 8'h01);
    chk("R5 cmd aborted", cmd_q, 0);
    clear_all();
  endtask

  task automatic t_slave_rx();
    node_master = 0;
    write_cmd(2'd1);
    ev_brk_sync = 1; step();
    chk("R6 framing error", err_word, 8'h10);
    chk("R6 cmd aborted", cmd_q, 0);
    clear_all();
    ev_brk_sync = 1; step();
    chk("R6 idle break no error", err_word, 0);
    write_cmd(2'd3);
    ev_brk_sync = 1; step();
    chk("R6 header break no error", err_word, 0);
    chk("R6 header cmd kept", cmd_q, 3);
    write_cmd(2'd0);
    chk("R7 slave idle write no abort", err_word, 0);
  endtask

  task automatic t_master();
    node_master = 1;
    write_cmd(2'd0);
    chk("R7 idle write no abort", err_word, 0);
    write_cmd(2'd1);
    ev_brk_sync = 1; step();
    chk("R7 master break cmd kept", cmd_q, 1);
    chk("R7 master break no error", err_word, 0);
    write_cmd(2'd0);
    chk("R7 abort flag", err_word, 8'h80);
    chk("R7 abort cmd idle", cmd_q, 0);
    write_cmd(2'd3);
    chk("R7 header after abort", cmd_q, 3);
    ev_id_ok = 1; step();
    clear_all();
    node_master = 0;
  endtask

  task automatic t_frame();
    ev_id_ok = 1; ev_tx_done = 1; ev_rx_done = 1; err_strobe = 8'h08; step();
    chk("R8 pre ok", status, 4'hF);
    ev_brk_sync = 1; step();
    chk("R8 ok cleared", status, 4'h8);
    chk("R8 errors kept", err_word, 8'h08);
    ev_brk_sync = 1; ev_id_ok = 1; step();
    chk("R8 event beats frame clear", status, 4'hC);
    clear_all();
  endtask

  task automatic t_irq();
    err_strobe = 8'h40; ev_id_ok = 1; step();
    chk("R9 irq_err disabled", irq_err, 0);
    chk("R10 irq_frame disabled", irq_frame, 0);
    en_wr = 1; en_wdata = 4'h8; step();
    chk("R9 en readback", en_q, 4'h8);
    chk("R9 irq_err", irq_err, 1);
    chk("R10 irq_frame off", irq_frame, 0);
    en_wr = 1; en_wdata = 4'h3; step();
    chk("R9 irq_err off", irq_err, 0);
    chk("R10 wrong enable", irq_frame, 0);
    en_wr = 1; en_wdata = 4'h4; step();
    chk("R10 irq_frame on", irq_frame, 1);
    clr_wr = 1; clr_ok_mask = 3'h4; step();
    chk("R10 irq_frame after clear", irq_frame, 0);
    ev_rx_done = 1; en_wr = 1; en_wdata = 4'h1; step();
    chk("R10 rx gated", irq_frame, 1);
    clear_all();
    chk("R9 irq_err after clear", irq_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1;
    step();
    t_errors();
    t_ok();
    t_cmd();
    t_slave_tx();
    t_slave_rx();
    t_master();
    t_frame();
    t_irq();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule